// File: doc/BRIEF.md
# Warm/Cold Hardware Reset Sequencer

This block sits between a chip's external active-low reset pin and its core. It runs on the CPU clock and passes the pin through a synchroniser. It measures how long the pin is held low, ignores glitches, and then runs a fixed sequence. The sequence has three phases:

- a short drain window, in which hold requests are cancelled and bus activity is wound down;
- a fixed internal reset interval, during which the block can pull its own reset pin low;
- a wait for the pin to be seen high again.

When the pin is seen high, the block records whether the pulse was a short (warm) or a long (cold) reset. It records whether the level pin selected synchronous or asynchronous completion. After a delay set by the PLL-bypass strap, it latches a start-up configuration word from an input port. In the same cycle it releases the core, which then fetches from address zero.

While the sequence runs, I/O enables are held in high impedance, the core is held and reset-out is low. Reset-out stays low after the release until the boot code pulses an end-of-initialisation strobe. The bidirectional pull-down on the reset pin is armed by a software-set enable bit. That bit is cleared at power-on and at the start of every sequence. A low level pin during the drain window or the interval disables the pull-down for the rest of the sequence.

Top module: `rsq_reset_seq`

## Requirements
- R1: The reset pin and the level pin each pass through two flops. A low pin seen for fewer than MIN_LOW_CLK (default 2) consecutive clocks is ignored: drain_active, io_hiz and rst_out_n do not change.
- R2: A low pin seen for MIN_LOW_CLK consecutive clocks starts a sequence. drain_active is high for exactly DRAIN_CLK (default 6) clocks, and io_hiz is high with rst_out_n low.
- R3: After the drain window, the internal interval lasts INTERVAL_CLK (default 512) clocks. io_hiz and core_hold stay high from the start of the sequence until core_release.
- R4: rst_pull is high for exactly the INTERVAL_CLK clocks of the interval, and only when bdr_en was 1 at the start of the sequence and the level pin stays high.
- R5: bdr_en is 0 after power-on and is cleared when a sequence starts. A bdr_set pulse sets it only while the core runs; a pulse during a sequence is ignored.
- R6: A synchronised low level pin during the drain window or the interval drops rst_pull at once and keeps it low for the rest of that sequence.
- R7: The pulse length counts the clocks on which the synchronised pin is low. It excludes clocks on which rst_pull is high, stops at the first high sample, and saturates. last_long is 1 when the length exceeds SHORT_MAX_CLK (default 519) and 0 otherwise, and it only changes at the exit.
- R8: Exit happens on the first high sample of the synchronised pin after the interval. At that sample, sync_exit takes the synchronised level pin: 1 selects synchronous completion and 0 selects asynchronous completion.
- R9: cfg_word loads cfg_port CFG_DELAY_CLK (default 4) clocks after the exit sample, or CFG_DELAY_BYP_CLK (default 3) clocks when pll_bypass is 1. core_release is high for that one clock, and io_hiz and core_hold fall with it.
- R10: rst_out_n stays 0 after core_release until eoi is pulsed while the core runs. It rises on the clock after that pulse. eoi during a sequence is ignored.
- R11: After power-on, rst_out_n=0, io_hiz=0, core_hold=0, bdr_en=0, last_long=1, sync_exit=0 and cfg_word=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Raw reset pin level, active low |
| lvl_pin | input | 1 | Raw level-pin comparator output |
| pll_bypass | input | 1 | Strap: PLL bypassed, shortens the latch delay |
| bdr_set | input | 1 | Software write that arms the bidirectional pull-down |
| eoi | input | 1 | End-of-initialisation strobe |
| cfg_port | input | CFG_W | Start-up configuration port |
| rst_pull | output | 1 | Drive the reset pin low |
| io_hiz | output | 1 | Force I/O enables to high impedance |
| core_hold | output | 1 | Hold the core in reset |
| drain_active | output | 1 | Cancel holds, finish internal access, abort external bus cycle |
| rst_out_n | output | 1 | Reset-out, active low |
| core_release | output | 1 | One-clock pulse: core starts fetching at address 0 |
| cfg_word | output | CFG_W | Latched configuration word |
| sync_exit | output | 1 | Last exit was synchronous |
| last_long | output | 1 | Last reset was long |
| bdr_en | output | 1 | Bidirectional pull-down enable bit |

## Verification
The assertions assume the following:

- The reset pin only changes between clock edges.
- bdr_set and eoi are single-cycle pulses.
- The level pin is held high while the pull-down is expected to run, except when the disable path is being exercised.

The bench drives every input at the falling clock edge. It models the reset pin as the wired AND of its own driver and rst_pull. It sweeps pulse lengths across both detection thresholds with a small configuration, and alternates the strap and the exit level on each length. For each length it derives the exit-to-release distance and the warm/cold result from the pulse length alone.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      RSQ_RUN   = 3'd0,
      RSQ_DRAIN = 3'd1,
      RSQ_INTV  = 3'd2,
      RSQ_WAIT  = 3'd3,
      RSQ_CFG   = 3'd4
   } rsq_state_e;

   function automatic int rsq_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("rsq_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] sh_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= RST_VAL;
         else        sh_q <= d;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= {STAGES{RST_VAL}};
         else        sh_q <= {sh_q[STAGES-2:0], d};
      end
   end

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rsq_len_meter.sv
module rsq_len_meter #(
   parameter int MIN_LOW_CLK   = 2,
   parameter int SHORT_MAX_CLK = 519
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic low,
   input  logic hold,
   output logic det_hit,
   output logic is_long
);

   localparam int LIMIT = SHORT_MAX_CLK + 1;
   localparam int CW    = $clog2(LIMIT + 1);

   if (MIN_LOW_CLK < 1 || MIN_LOW_CLK > SHORT_MAX_CLK) begin : g_bad_min
      $error("rsq_len_meter: MIN_LOW_CLK must lie in 1..SHORT_MAX_CLK");
   end

   logic [CW-1:0] cnt_q;
   logic          frozen_q;
   logic          at_lim;
   logic [CW-1:0] cnt_inc;

   assign at_lim  = (cnt_q == CW'(LIMIT));
   assign cnt_inc = at_lim ? cnt_q : cnt_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         frozen_q <= 1'b1;
      end else if (arm) begin
         cnt_q    <= low ? cnt_inc : '0;
         frozen_q <= 1'b0;
      end else if (!low) begin
         frozen_q <= 1'b1;
      end else if (!frozen_q && !hold) begin
         cnt_q    <= cnt_inc;
      end
   end

   assign det_hit = arm && low && (cnt_q == CW'(MIN_LOW_CLK - 1));
   assign is_long = at_lim;

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
   import rsq_pkg::*;
#(
   parameter int DRAIN_CLK         = 6,
   parameter int INTERVAL_CLK      = 512,
   parameter int CFG_DELAY_CLK     = 4,
   parameter int CFG_DELAY_BYP_CLK = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       det_hit,
   input  logic       pin_s,
   input  logic       pll_bypass,
   input  logic       eoi,
   output rsq_state_e state,
   output logic       seq_start,
   output logic       exit_go,
   output logic       latch_go,
   output logic       core_release,
   output logic       rst_out_n
);

   localparam int MAXT = rsq_max4(DRAIN_CLK, INTERVAL_CLK, CFG_DELAY_CLK, CFG_DELAY_BYP_CLK);
   localparam int TW   = (MAXT > 1) ? $clog2(MAXT) : 1;

   if (DRAIN_CLK < 1 || INTERVAL_CLK < 1 || CFG_DELAY_CLK < 1 || CFG_DELAY_BYP_CLK < 1) begin : g_bad_time
      $error("rsq_fsm: every phase length must be at least 1 clock");
   end

   rsq_state_e st_q, st_d;
   logic [TW-1:0] tmr_q, tmr_d;
   logic [TW-1:0] cfg_dly;

   assign cfg_dly   = pll_bypass ? TW'(CFG_DELAY_BYP_CLK - 1) : TW'(CFG_DELAY_CLK - 1);
   assign seq_start = (st_q == RSQ_RUN) && det_hit;
   assign exit_go   = (st_q == RSQ_WAIT) && pin_s;
   assign latch_go  = (st_q == RSQ_CFG) && (tmr_q == '0);

   always_comb begin
      st_d  = st_q;
      tmr_d = (tmr_q == '0) ? tmr_q : tmr_q - 1'b1;
      unique case (st_q)
         RSQ_RUN: begin
            if (seq_start) begin
               st_d  = RSQ_DRAIN;
               tmr_d = TW'(DRAIN_CLK - 1);
            end
         end
         RSQ_DRAIN: begin
            if (tmr_q == '0) begin
               st_d  = RSQ_INTV;
               tmr_d = TW'(INTERVAL_CLK - 1);
            end
         end
         RSQ_INTV: begin
            if (tmr_q == '0) st_d = RSQ_WAIT;
         end
         RSQ_WAIT: begin
            if (exit_go) begin
               st_d  = RSQ_CFG;
               tmr_d = cfg_dly;
            end
         end
         RSQ_CFG: begin
            if (latch_go) st_d = RSQ_RUN;
         end
         default: begin
            st_d  = RSQ_RUN;
            tmr_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= RSQ_RUN;
         tmr_q        <= '0;
         core_release <= 1'b0;
         rst_out_n    <= 1'b0;
      end else begin
         st_q         <= st_d;
         tmr_q        <= tmr_d;
         core_release <= latch_go;
         if (seq_start)                    rst_out_n <= 1'b0;
         else if (st_q == RSQ_RUN && eoi)  rst_out_n <= 1'b1;
      end
   end

   assign state = st_q;

endmodule

// File: rtl/rsq_cfg_latch.sv
module rsq_cfg_latch #(
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CFG_W-1:0] port,
   output logic [CFG_W-1:0] word
);

   if (CFG_W < 1) begin : g_bad_w
      $error("rsq_cfg_latch: CFG_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word <= '0;
      else if (load) word <= port;
   end

endmodule

// File: rtl/rsq_reset_seq.sv
module rsq_reset_seq
   import rsq_pkg::*;
#(
   parameter int SYNC_STAGES       = 2,
   parameter int MIN_LOW_CLK       = 2,
   parameter int DRAIN_CLK         = 6,
   parameter int INTERVAL_CLK      = 512,
   parameter int SHORT_MAX_CLK     = 519,
   parameter int CFG_DELAY_CLK     = 4,
   parameter int CFG_DELAY_BYP_CLK = 3,
   parameter int CFG_W             = 16
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_pin_n,
   input  logic             lvl_pin,
   input  logic             pll_bypass,
   input  logic             bdr_set,
   input  logic             eoi,
   input  logic [CFG_W-1:0] cfg_port,
   output logic             rst_pull,
   output logic             io_hiz,
   output logic             core_hold,
   output logic             drain_active,
   output logic             rst_out_n,
   output logic             core_release,
   output logic [CFG_W-1:0] cfg_word,
   output logic             sync_exit,
   output logic             last_long,
   output logic             bdr_en
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rsq_reset_seq: SYNC_STAGES must be at least 2");
   end

   logic       pin_s, lvl_s;
   logic       det_hit, meter_long;
   rsq_state_e state;
   logic       seq_start, exit_go, latch_go;
   logic       pull_arm_q, pull_kill_q;
   logic       in_drain_or_intv;

   rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_pin_sync (
      .clk(clk), .rst_n(por_n), .d(rst_pin_n), .q(pin_s));

   rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_lvl_sync (
      .clk(clk), .rst_n(por_n), .d(lvl_pin), .q(lvl_s));

   rsq_len_meter #(.MIN_LOW_CLK(MIN_LOW_CLK), .SHORT_MAX_CLK(SHORT_MAX_CLK)) i_meter (
      .clk(clk), .rst_n(por_n), .arm(state == RSQ_RUN), .low(!pin_s), .hold(rst_pull),
      .det_hit(det_hit), .is_long(meter_long));

   rsq_fsm #(
      .DRAIN_CLK(DRAIN_CLK), .INTERVAL_CLK(INTERVAL_CLK),
      .CFG_DELAY_CLK(CFG_DELAY_CLK), .CFG_DELAY_BYP_CLK(CFG_DELAY_BYP_CLK)
   ) i_fsm (
      .clk(clk), .rst_n(por_n), .det_hit(det_hit), .pin_s(pin_s),
      .pll_bypass(pll_bypass), .eoi(eoi), .state(state), .seq_start(seq_start),
      .exit_go(exit_go), .latch_go(latch_go), .core_release(core_release),
      .rst_out_n(rst_out_n));

   rsq_cfg_latch #(.CFG_W(CFG_W)) i_cfg (
      .clk(clk), .rst_n(por_n), .load(latch_go), .port(cfg_port), .word(cfg_word));

   assign in_drain_or_intv = (state == RSQ_DRAIN) || (state == RSQ_INTV);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         bdr_en      <= 1'b0;
         pull_arm_q  <= 1'b0;
         pull_kill_q <= 1'b0;
         last_long   <= 1'b1;
         sync_exit   <= 1'b0;
      end else begin
         if (seq_start) begin
            pull_arm_q  <= bdr_en;
            bdr_en      <= 1'b0;
            pull_kill_q <= 1'b0;
         end else begin
            if (state == RSQ_RUN && bdr_set) bdr_en <= 1'b1;
            if (in_drain_or_intv && !lvl_s)  pull_kill_q <= 1'b1;
         end
         if (exit_go) begin
            last_long <= meter_long;
            sync_exit <= lvl_s;
         end
      end
   end

   assign rst_pull     = (state == RSQ_INTV) && pull_arm_q && !pull_kill_q && lvl_s;
   assign io_hiz       = (state != RSQ_RUN);
   assign core_hold    = (state != RSQ_RUN);
   assign drain_active = (state == RSQ_DRAIN);

endmodule

// File: rtl/rsq_reset_seq_chk.sv
module rsq_reset_seq_chk (
   input logic clk,
   input logic por_n,
   input logic eoi,
   input logic rst_pull,
   input logic io_hiz,
   input logic core_hold,
   input logic drain_active,
   input logic rst_out_n,
   input logic core_release,
   input logic last_long,
   input logic bdr_en
);

   p_drain_hiz_r2: assert property (@(posedge clk) disable iff (!por_n)
      drain_active |-> (io_hiz && core_hold && !rst_out_n))
      else $error("drain window without hiz/hold/reset-out");

   p_hiz_until_release_r3: assert property (@(posedge clk) disable iff (!por_n)
      $fell(io_hiz) |-> core_release)
      else $error("hiz released without core release");

   p_pull_in_seq_r4: assert property (@(posedge clk) disable iff (!por_n)
      rst_pull |-> (io_hiz && !drain_active && !rst_out_n))
      else $error("pull-down outside the interval");

   p_bdr_cleared_r5: assert property (@(posedge clk) disable iff (!por_n)
      $rose(drain_active) |-> !bdr_en)
      else $error("enable bit not cleared at sequence start");

   p_class_stable_r7: assert property (@(posedge clk) disable iff (!por_n)
      (!io_hiz && $past(!io_hiz)) |-> $stable(last_long))
      else $error("classification changed while running");

   p_release_pulse_r9: assert property (@(posedge clk) disable iff (!por_n)
      core_release |-> ($past(io_hiz) && !io_hiz))
      else $error("release not at end of sequence");

   p_release_single_r9: assert property (@(posedge clk) disable iff (!por_n)
      core_release |=> !core_release)
      else $error("release longer than one clock");

   p_rstout_rise_r10: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_out_n) |-> ($past(eoi) && !io_hiz))
      else $error("reset-out rose without strobe");

endmodule

bind rsq_reset_seq rsq_reset_seq_chk i_rsq_chk (.*);

// File: tb/test_rsq_reset_seq.sv
module test_rsq_reset_seq;

   localparam int MIN = 2;
   localparam int DR  = 3;
   localparam int IV  = 12;
   localparam int SM  = 20;
   localparam int DP  = 4;
   localparam int DB  = 3;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_n = 1'b1;
   logic       lvl_pin = 1'b1;
   logic       pll_bypass = 1'b0;
   logic       bdr_set = 1'b0;
   logic       eoi = 1'b0;
   logic [7:0] cfg_port = '0;
   logic       pin_w;
   logic       rst_pull, io_hiz, core_hold, drain_active, rst_out_n, core_release;
   logic [7:0] cfg_word;
   logic       sync_exit, last_long, bdr_en;

   int n_vec = 0;
   int n_bad = 0;
   int n_drain = 0;
   int n_pull = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   assign pin_w = ext_n & ~rst_pull;

   rsq_reset_seq #(
      .SYNC_STAGES(2), .MIN_LOW_CLK(MIN), .DRAIN_CLK(DR), .INTERVAL_CLK(IV),
      .SHORT_MAX_CLK(SM), .CFG_DELAY_CLK(DP), .CFG_DELAY_BYP_CLK(DB), .CFG_W(8)
   ) i_rsq_reset_seq (
      .clk(clk), .por_n(por_n), .rst_pin_n(pin_w), .lvl_pin(lvl_pin),
      .pll_bypass(pll_bypass), .bdr_set(bdr_set), .eoi(eoi), .cfg_port(cfg_port),
      .rst_pull(rst_pull), .io_hiz(io_hiz), .core_hold(core_hold),
      .drain_active(drain_active), .rst_out_n(rst_out_n), .core_release(core_release),
      .cfg_word(cfg_word), .sync_exit(sync_exit), .last_long(last_long), .bdr_en(bdr_en));

   always @(negedge clk) begin
      #1;
      if (drain_active) n_drain++;
      if (rst_pull)     n_pull++;
   end

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         report();
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", what, act, exp);
      end
   endtask

   // One full reset: pin driven low for len clocks, then released.
   task automatic do_reset(input int len, input bit bdr, input bit lvl_x, input bit byp,
                           input bit kill, input bit poke, input logic [7:0] cfg);
      int  pf;
      int  k;
      int  dly;
      int  eff;
      int  exp_k;
      bit  found;
      @(negedge clk);
      if (bdr) begin
         bdr_set = 1'b1;
         @(negedge clk);
         bdr_set = 1'b0;
         chk("R5 bdr_en set while running", int'(bdr_en), 1);
      end
      cfg_port   = cfg;
      pll_bypass = byp;
      n_drain    = 0;
      n_pull     = 0;
      ext_n      = 1'b0;
      pf         = -1;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (poke && drain_active) begin bdr_set = 1'b1; eoi = 1'b1; end
         else begin bdr_set = 1'b0; eoi = 1'b0; end
         if (kill) begin
            if (pf < 0 && rst_pull) pf = i;
            if (pf >= 0 && i == pf + 2) lvl_pin = 1'b0;
            if (pf >= 0 && i == pf + 5) begin
               chk("R6 pull dropped on low level", int'(rst_pull), 0);
               lvl_pin = 1'b1;
            end
            if (pf >= 0 && i == pf + 8) chk("R6 pull stays off after level recovers", int'(rst_pull), 0);
         end
      end
      bdr_set = 1'b0;
      eoi     = 1'b0;
      lvl_pin = lvl_x;
      ext_n   = 1'b1;
      k = 0;
      found = 1'b0;
      for (int j = 1; j <= 200 && !found; j++) begin
         @(negedge clk);
         if (core_release) begin k = j; found = 1'b1; end
      end
      chk("R9 core_release seen", int'(found), 1);
      dly = byp ? DB : DP;
      exp_k = MIN + DR + IV + 3 + dly - len;
      if (exp_k < 3 + dly) exp_k = 3 + dly;
      if (!bdr || len >= MIN + DR + IV) chk("R9 rise-to-release clocks", k, exp_k);
      chk("R9 cfg_word latched", int'(cfg_word), int'(cfg));
      chk("R3 io_hiz low after release", int'(io_hiz), 0);
      chk("R3 core_hold low after release", int'(core_hold), 0);
      chk("R10 rst_out_n still low", int'(rst_out_n), 0);
      chk("R2 drain window length", n_drain, DR);
      if (!kill) chk("R4 pull-down clocks", n_pull, bdr ? IV : 0);
      eff = (bdr && !kill && len >= MIN + DR + IV) ? len - IV : len;
      if (kill) eff = SM + 1;
      chk("R7 last_long", int'(last_long), (eff > SM) ? 1 : 0);
      chk("R8 sync_exit", int'(sync_exit), int'(lvl_x));
      chk("R5 bdr_en cleared", int'(bdr_en), 0);
      lvl_pin = 1'b1;
      @(negedge clk);
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
      chk("R10 rst_out_n after eoi", int'(rst_out_n), 1);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      chk("R11 rst_out_n at power-on", int'(rst_out_n), 0);
      chk("R11 io_hiz at power-on", int'(io_hiz), 0);
      chk("R11 core_hold at power-on", int'(core_hold), 0);
      chk("R11 bdr_en at power-on", int'(bdr_en), 0);
      chk("R11 last_long at power-on", int'(last_long), 1);
      chk("R11 sync_exit at power-on", int'(sync_exit), 0);
      chk("R11 cfg_word at power-on", int'(cfg_word), 0);
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
      chk("R10 rst_out_n after first eoi", int'(rst_out_n), 1);

      // R1: glitches shorter than MIN clocks
      for (int g = 1; g < MIN; g++) begin
         n_drain = 0;
         ext_n = 1'b0;
         repeat (g) @(negedge clk);
         ext_n = 1'b1;
         repeat (8) @(negedge clk);
         chk("R1 glitch: no drain", n_drain, 0);
         chk("R1 glitch: io_hiz", int'(io_hiz), 0);
         chk("R1 glitch: rst_out_n", int'(rst_out_n), 1);
      end

      // R2 R7 R8 R9: sweep of pulse lengths across both thresholds
      for (int len = MIN; len <= SM + 4; len++)
         do_reset(len, 1'b0, (len % 3) != 0, len[0], 1'b0, 1'b0, 8'(len * 37 + 5));
      do_reset(60, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5);
      do_reset(60, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h5A);

      // R4 R7: pull-down armed, clocks under pull not counted
      do_reset(30, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C);
      do_reset(30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC3);
      do_reset(MIN + 1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0F);
      do_reset(40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hF0);

      // R6: level pin drop disables the pull-down
      do_reset(40, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h99);

      // R5 R10: bdr_set and eoi during a sequence are ignored
      do_reset(30, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h66);
      do_reset(30, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h77);

      report();
   end

endmodule